// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits between an 8-bit processor bus with a 16-bit address and external ROM and RAM arrays. The processor writes into the ROM address space to set control registers. These registers are a 9-bit ROM bank number, a RAM bank number and a RAM enable flag. Reads in the lower half of the map go to ROM. The lower 16 KiB window is fixed on bank 0, and the upper 16 KiB window follows the selected bank. An 8 KiB window at 0xA000 reaches banked external RAM. The block produces physical ROM and RAM addresses, returns read data or 0xFF, and gates the RAM write strobe.

Every address is first sorted into one of seven named regions: ENABLE (0x0000–0x1FFF), ROMLO (0x2000–0x2FFF), ROMHI (0x3000–0x3FFF), RAMSEL (0x4000–0x5FFF), SPARE (0x6000–0x7FFF), RAMWIN (0xA000–0xBFFF) and NONE (everything else). Both the register updates and the read-data selection are driven by a `unique case` on that region.

The bank counts are power-of-two parameters. A RAM-presence parameter turns the RAM path off. A motor parameter selects the variant in which RAM-select data bit 3 drives a motor line instead of a bank bit.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A write in region ENABLE sets the RAM enable flag when data bits 3:0 equal 0xA and clears it otherwise (0x1A enables, 0x0B disables).
- R2: A write in region ROMLO loads ROM bank bits 7:0 from the data and keeps bank bit 8.
- R3: A write in region ROMHI loads data bit 0 into ROM bank bit 8 and ignores data bits 7:1. ROM bank bits 7:0 are kept.
- R4: A synchronous active-high reset sets the ROM bank to 1, the RAM bank to 0, RAM enable to 0 and the motor output to 0. A later write of 0 in region ROMLO (with bit 8 clear) selects bank 0 in the switchable window, with no substitution of bank 1.
- R5: Reads at 0x0000–0x3FFF produce `rom_addr` = the CPU address, which is bank 0. `cpu_rdata` returns `rom_rdata` in the same cycle.
- R6: Reads at 0x4000–0x7FFF produce `rom_addr` = (ROM bank AND (ROM_BANKS−1))×0x4000 + (address − 0x4000), and `cpu_rdata` returns `rom_rdata`. For example, bank 5 with 4 banks gives bank 1.
- R7: In the normal variant a write in region RAMSEL loads the RAM bank from data bits 3:0. In the RAM window, `ram_addr` = (RAM bank AND (RAM_BANKS−1))×0x2000 + (address − 0xA000).
- R8: In the motor variant a write in region RAMSEL loads the RAM bank from data bits 2:0, and data bit 3 goes to `motor_on`. In the normal variant `motor_on` stays 0.
- R9: In the RAM window `cpu_rdata` returns `ram_rdata` only when RAM is enabled and present, and 0xFF otherwise. `ram_we` is high only in the cycle of a CPU write that hits the RAM window while RAM is enabled and present.
- R10: Reads outside 0x0000–0x7FFF and 0xA000–0xBFFF return 0xFF. Writes in region SPARE or region NONE change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_rdata | output | 8 | Read data to the processor |
| rom_addr | output | ROM_AW | Physical ROM byte address |
| rom_rdata | input | 8 | ROM array data |
| ram_addr | output | RAM_AW | Physical RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM array data |
| ram_we | output | 1 | RAM write enable |
| motor_on | output | 1 | Motor drive line (motor variant only) |

## Verification
The bench targets these corner cases:
- The split ROM bank write. A design that cleared bit 8 on a low-byte write, or took all of the high-byte data, would fetch from the wrong half of a 512-bank ROM.
- An explicit bank-0 select. A controller that promotes bank 0 to bank 1 would return bank 1 data in the upper window.
- Bank masking on small arrays, where a bank number above the array size has to wrap instead of addressing past the end.
- The motor variant. Leaking bit 3 into the RAM bank, or into the motor line of the normal variant, shows up as wrong RAM addresses or a stray motor pulse.
- The RAM write strobe. Writes while RAM is disabled, and writes with no RAM present, must leave the strobe low.
- Unmapped reads. These must return 0xFF rather than stale array data.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 16;
    localparam int ROM_BANK_W = 9;
    localparam int RAM_BANK_W = 4;

    typedef enum logic [2:0] {
        RG_ENABLE,
        RG_ROMLO,
        RG_ROMHI,
        RG_RAMSEL,
        RG_SPARE,
        RG_RAMWIN,
        RG_NONE
    } region_t;
endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
    import cbc_pkg::*;
(
    input  logic [3:0] addr_hi,
    output region_t    rgn
);
    always_comb begin
        unique case (addr_hi)
            4'h0, 4'h1: rgn = RG_ENABLE;
            4'h2:       rgn = RG_ROMLO;
            4'h3:       rgn = RG_ROMHI;
            4'h4, 4'h5: rgn = RG_RAMSEL;
            4'h6, 4'h7: rgn = RG_SPARE;
            4'hA, 4'hB: rgn = RG_RAMWIN;
            default:    rgn = RG_NONE;
        endcase
    end
endmodule

// File: rtl/cbc_regs.sv
module cbc_regs
    import cbc_pkg::*;
#(
    parameter bit MOTOR_VARIANT = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  region_t               rgn,
    input  logic [DATA_W-1:0]     wdata,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic                  ram_en,
    output logic                  motor_on
);
    logic [RAM_BANK_W-1:0] sel_bank;
    logic                  sel_motor;

    generate
        if (MOTOR_VARIANT) begin : g_motor
            assign sel_bank  = {1'b0, wdata[2:0]};
            assign sel_motor = wdata[3];
        end else begin : g_plain
            assign sel_bank  = wdata[RAM_BANK_W-1:0];
            assign sel_motor = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rom_bank <= ROM_BANK_W'(1);
            ram_bank <= '0;
            ram_en   <= 1'b0;
            motor_on <= 1'b0;
        end else if (wr) begin
            unique case (rgn)
                RG_ENABLE: ram_en        <= (wdata[3:0] == 4'hA);
                RG_ROMLO:  rom_bank[7:0] <= wdata;
                RG_ROMHI:  rom_bank[8]   <= wdata[0];
                RG_RAMSEL: begin
                    ram_bank <= sel_bank;
                    motor_on <= sel_motor;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/cbc_xlate.sv
module cbc_xlate
    import cbc_pkg::*;
#(
    parameter int ROM_AW  = 23,
    parameter int RAM_AW  = 17,
    parameter bit HAS_RAM = 1'b1
) (
    input  logic [14:0]           cpu_addr,
    input  region_t               rgn,
    input  logic                  cpu_wr,
    input  logic [ROM_BANK_W-1:0] rom_bank,
    input  logic [RAM_BANK_W-1:0] ram_bank,
    input  logic                  ram_en,
    input  logic [DATA_W-1:0]     rom_rdata,
    input  logic [DATA_W-1:0]     ram_rdata,
    output logic [ROM_AW-1:0]     rom_addr,
    output logic [RAM_AW-1:0]     ram_addr,
    output logic                  ram_we,
    output logic [DATA_W-1:0]     cpu_rdata
);
    localparam int ROM_FULL = ROM_BANK_W + 14;
    localparam int RAM_FULL = RAM_BANK_W + 13;

    logic [ROM_BANK_W-1:0] win_bank;
    logic [ROM_FULL-1:0]   rom_full;
    logic [RAM_FULL-1:0]   ram_full;
    logic                  ram_live;

    // Truncating the full address to the array width masks the bank number.
    assign win_bank = cpu_addr[14] ? rom_bank : '0;
    assign rom_full = {win_bank, cpu_addr[13:0]};
    assign ram_full = {ram_bank, cpu_addr[12:0]};
    assign rom_addr = rom_full[ROM_AW-1:0];
    assign ram_addr = ram_full[RAM_AW-1:0];

    assign ram_live = ram_en & HAS_RAM;
    assign ram_we   = cpu_wr && (rgn == RG_RAMWIN) && ram_live;

    always_comb begin
        unique case (rgn)
            RG_ENABLE, RG_ROMLO, RG_ROMHI,
            RG_RAMSEL, RG_SPARE: cpu_rdata = rom_rdata;
            RG_RAMWIN:           cpu_rdata = ram_live ? ram_rdata : 8'hFF;
            default:             cpu_rdata = 8'hFF;
        endcase
    end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cbc_pkg::*;
#(
    parameter int ROM_BANKS     = 512,
    parameter int RAM_BANKS     = 16,
    parameter bit HAS_RAM       = 1'b1,
    parameter bit MOTOR_VARIANT = 1'b0,
    localparam int ROM_AW = $clog2(ROM_BANKS) + 14,
    localparam int RAM_AW = $clog2(RAM_BANKS) + 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_wr,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [DATA_W-1:0] rom_rdata,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              ram_we,
    output logic              motor_on
);
    region_t               rgn;
    logic [ROM_BANK_W-1:0] rom_bank;
    logic [RAM_BANK_W-1:0] ram_bank;
    logic                  ram_en;

    cbc_decode u_decode (
        .addr_hi (cpu_addr[15:12]),
        .rgn     (rgn)
    );

    cbc_regs #(.MOTOR_VARIANT(MOTOR_VARIANT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (cpu_wr),
        .rgn      (rgn),
        .wdata    (cpu_wdata),
        .rom_bank (rom_bank),
        .ram_bank (ram_bank),
        .ram_en   (ram_en),
        .motor_on (motor_on)
    );

    cbc_xlate #(.ROM_AW(ROM_AW), .RAM_AW(RAM_AW), .HAS_RAM(HAS_RAM)) u_xlate (
        .cpu_addr  (cpu_addr[14:0]),
        .rgn       (rgn),
        .cpu_wr    (cpu_wr),
        .rom_bank  (rom_bank),
        .ram_bank  (ram_bank),
        .ram_en    (ram_en),
        .rom_rdata (rom_rdata),
        .ram_rdata (ram_rdata),
        .rom_addr  (rom_addr),
        .ram_addr  (ram_addr),
        .ram_we    (ram_we),
        .cpu_rdata (cpu_rdata)
    );

    assign ram_wdata = cpu_wdata;
endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk #(
    parameter int ROM_AW        = 23,
    parameter bit MOTOR_VARIANT = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              cpu_wr,
    input logic [7:0]        cpu_rdata,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              ram_we,
    input logic              motor_on,
    input logic [8:0]        rom_bank,
    input logic [3:0]        ram_bank,
    input logic              ram_en
);
    // R1
    enable_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:13] == 3'b000)
        |=> (ram_en == ($past(cpu_wdata[3:0]) == 4'hA)));

    // R2
    low_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:12] == 4'h2)
        |=> (rom_bank[7:0] == $past(cpu_wdata) && rom_bank[8] == $past(rom_bank[8])));

    // R3
    high_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr[15:12] == 4'h3)
        |=> (rom_bank[7:0] == $past(rom_bank[7:0]) && rom_bank[8] == $past(cpu_wdata[0])));

    // R4
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rom_bank == 9'd1 && ram_bank == 4'd0 && !ram_en && !motor_on));

    // R5
    fixed_window_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:14] == 2'b00) |-> (rom_addr[ROM_AW-1:14] == '0));

    // R8
    motor_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !MOTOR_VARIANT |-> !motor_on);

    // R8
    motor_load_chk: assert property (@(posedge clk) disable iff (rst)
        (MOTOR_VARIANT && cpu_wr && cpu_addr[15:13] == 3'b010)
        |=> (!ram_bank[3] && motor_on == $past(cpu_wdata[3])));

    // R9
    ram_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (cpu_wr && ram_en && cpu_addr[15:13] == 3'b101));

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:13] == 3'b100 || cpu_addr[15:14] == 2'b11) |-> (cpu_rdata == 8'hFF));
endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(.ROM_AW(ROM_AW), .MOTOR_VARIANT(MOTOR_VARIANT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_wr    (cpu_wr),
    .cpu_rdata (cpu_rdata),
    .rom_addr  (rom_addr),
    .ram_we    (ram_we),
    .motor_on  (motor_on),
    .rom_bank  (rom_bank),
    .ram_bank  (ram_bank),
    .ram_en    (ram_en)
);

// File: tb/cart_bank_ctrl_test.sv
module cart_bank_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_wr = 1'b0;

    always #5 clk = ~clk;

    function automatic int romf(int a);
        return (a ^ (a >>> 14) ^ (a >>> 7)) & 255;
    endfunction
    function automatic int ramf(int a);
        return (((a >>> 13) * 37) + a + 8'h3C) & 255;
    endfunction

    // instance 0: 512 ROM banks, 2 RAM banks, normal
    logic [22:0] ra0; logic [13:0] wa0; logic [7:0] rd0, wd0, rr0, mr0; logic we0, mo0;
    // instance 1: 4 ROM banks, 8 RAM banks, motor variant
    logic [15:0] ra1; logic [15:0] wa1; logic [7:0] rd1, wd1, rr1, mr1; logic we1, mo1;
    // instance 2: 4 ROM banks, no RAM, normal
    logic [15:0] ra2; logic [12:0] wa2; logic [7:0] rd2, wd2, rr2, mr2; logic we2, mo2;

    assign rr0 = 8'(romf(int'(ra0)));  assign mr0 = 8'(ramf(int'(wa0)));
    assign rr1 = 8'(romf(int'(ra1)));  assign mr1 = 8'(ramf(int'(wa1)));
    assign rr2 = 8'(romf(int'(ra2)));  assign mr2 = 8'(ramf(int'(wa2)));

    cart_bank_ctrl #(.ROM_BANKS(512), .RAM_BANKS(2), .HAS_RAM(1'b1), .MOTOR_VARIANT(1'b0)) uut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
        .cpu_rdata(rd0), .rom_addr(ra0), .rom_rdata(rr0), .ram_addr(wa0), .ram_wdata(wd0),
        .ram_rdata(mr0), .ram_we(we0), .motor_on(mo0));
    cart_bank_ctrl #(.ROM_BANKS(4), .RAM_BANKS(8), .HAS_RAM(1'b1), .MOTOR_VARIANT(1'b1)) uut_m (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
        .cpu_rdata(rd1), .rom_addr(ra1), .rom_rdata(rr1), .ram_addr(wa1), .ram_wdata(wd1),
        .ram_rdata(mr1), .ram_we(we1), .motor_on(mo1));
    cart_bank_ctrl #(.ROM_BANKS(4), .RAM_BANKS(1), .HAS_RAM(1'b0), .MOTOR_VARIANT(1'b0)) uut_n (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr),
        .cpu_rdata(rd2), .rom_addr(ra2), .rom_rdata(rr2), .ram_addr(wa2), .ram_wdata(wd2),
        .ram_rdata(mr2), .ram_we(we2), .motor_on(mo2));

    // reference model
    int rb[3] = '{512, 4, 4};
    int ab[3] = '{2, 8, 1};
    int hr[3] = '{1, 1, 0};
    int mm[3] = '{0, 1, 0};
    int mrom[3], mram[3], men[3], mmot[3];

    int    nvec = 0;
    int    nbad = 0;
    string cur_req = "R4";
    bit    done = 1'b0;

    task automatic chk(int i, string what, int act, int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s inst%0d %s act=%0h exp=%0h (addr=%04h)", cur_req, i, what, act, exp, cpu_addr);
        end
    endtask

    task automatic cmp(int i, int ra, int wa, int rd, int we, int mo, int wd);
        int a = int'(cpu_addr);
        int d = int'(cpu_wdata);
        int era, ewa, erd, ewe, live;
        live = men[i] & hr[i];
        era = (a < 'h4000) ? a : ((mrom[i] & (rb[i] - 1)) * 'h4000 + (a - 'h4000));
        ewa = (mram[i] & (ab[i] - 1)) * 'h2000 + (a & 'h1FFF);
        if (a < 'h8000) erd = romf(era);
        else if (a >= 'hA000 && a < 'hC000) erd = live ? ramf(ewa) : 'hFF;
        else erd = 'hFF;
        ewe = (cpu_wr && a >= 'hA000 && a < 'hC000 && live) ? 1 : 0;
        if (a < 'h8000) chk(i, "rom_addr", ra, era);
        if (a >= 'hA000 && a < 'hC000) begin
            chk(i, "ram_addr", wa, ewa);
            chk(i, "ram_wdata", wd, d);
        end
        chk(i, "cpu_rdata", rd, erd);
        chk(i, "ram_we", we, ewe);
        chk(i, "motor_on", mo, mmot[i]);
    endtask

    task automatic upd(int i);
        int a = int'(cpu_addr);
        int d = int'(cpu_wdata);
        if (rst) begin
            mrom[i] = 1; mram[i] = 0; men[i] = 0; mmot[i] = 0;
        end else if (cpu_wr) begin
            if (a < 'h2000) men[i] = ((d & 15) == 10) ? 1 : 0;
            else if (a < 'h3000) mrom[i] = (mrom[i] & 256) | d;
            else if (a < 'h4000) mrom[i] = (mrom[i] & 255) | ((d & 1) << 8);
            else if (a < 'h6000) begin
                if (mm[i] != 0) begin mram[i] = d & 7; mmot[i] = (d >> 3) & 1; end
                else mram[i] = d & 15;
            end
        end
    endtask

    task automatic step(int ta, int td, bit tw, bit tr = 1'b0);
        cpu_addr  = 16'(ta);
        cpu_wdata = 8'(td);
        cpu_wr    = tw;
        rst       = tr;
        #2;
        if (!tr) begin
            cmp(0, int'(ra0), int'(wa0), int'(rd0), int'(we0), int'(mo0), int'(wd0));
            cmp(1, int'(ra1), int'(wa1), int'(rd1), int'(we1), int'(mo1), int'(wd1));
            cmp(2, int'(ra2), int'(wa2), int'(rd2), int'(we2), int'(mo2), int'(wd2));
        end
        @(posedge clk);
        for (int i = 0; i < 3; i++) upd(i);
        @(negedge clk);
    endtask

    task automatic rd(int ta); step(ta, 0, 1'b0); endtask
    task automatic wr(int ta, int td); step(ta, td, 1'b1); endtask

    initial begin
        @(negedge clk);
        step(0, 0, 1'b0, 1'b1);
        step('h2000, 'h00, 1'b1, 1'b1);   // write during reset is overridden
        // R4 reset state: bank 1 in upper window, RAM off, motor low
        cur_req = "R4";
        rd('h4000); rd('h7FFF); rd('hA000);
        // R1 enable decoding on low nibble
        cur_req = "R1";
        wr('h0000, 'h1A); rd('hA000);
        wr('h1FFF, 'h0B); rd('hA000);
        wr('h0ABC, 'h0A); rd('hA123);
        // R2 low byte load keeps bit 8
        cur_req = "R2";
        wr('h2000, 'h02); rd('h4000); rd('h7FFF);
        wr('h3000, 'h01); wr('h2ABC, 'h05); rd('h4000); rd('h6001);
        // R3 high bit load, other data bits ignored
        cur_req = "R3";
        wr('h2000, 'hFF); wr('h3FFF, 'h01); rd('h4000);
        wr('h3000, 'hFE); rd('h4000); rd('h7ABC);
        wr('h3456, 'h03); rd('h5555);
        // R4 explicit zero selects bank 0
        cur_req = "R4";
        wr('h3000, 'h00); wr('h2000, 'h00); rd('h4000); rd('h7FFF);
        // R5 fixed window independent of bank register
        cur_req = "R5";
        wr('h2000, 'h03); rd('h0000); rd('h3FFF); rd('h1234);
        // R6 switchable window with masking (bank 5 on 4 banks -> 1)
        cur_req = "R6";
        wr('h2000, 'h05); rd('h4000); rd('h5A5A);
        wr('h2000, 'hC2); rd('h7FFE);
        // R7 RAM bank select and RAM address
        cur_req = "R7";
        wr('h4000, 'h01); rd('hA000); rd('hBFFF);
        wr('h5FFF, 'h0F); rd('hA800);
        wr('h4000, 'h06); rd('hB001);
        // R8 motor variant bit 3
        cur_req = "R8";
        wr('h4000, 'h08); rd('hA000); rd('hA010);
        wr('h4000, 'h0F); rd('hA020);
        wr('h4000, 'h07); rd('hA030);
        wr('h5000, 'h00); rd('hA040);
        // R9 RAM strobe and read gating
        cur_req = "R9";
        wr('hA000, 'h42); wr('hBFFF, 'h99); rd('hA000);
        wr('h0000, 'h00); wr('hA000, 'h42); rd('hA000);
        wr('h0000, 'h0A); wr('hB000, 'h11);
        // R10 unmapped reads and writes
        cur_req = "R10";
        wr('h6000, 'h00); wr('h7FFF, 'h0B); wr('h8000, 'h00); wr('hC000, 'h00); wr('hFFFF, 'h00);
        rd('h4000); rd('hA000); rd('h8000); rd('h9FFF); rd('hC000); rd('hFE00); rd('hFFFF);
        // R6 sweep of bank values through both windows
        cur_req = "R6";
        for (int k = 0; k < 64; k++) begin
            wr('h2000, (k * 29) & 255);
            wr('h3000, k & 1);
            rd('h4000 + k * 97);
            rd((k * 211) & 'h3FFF);
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            nbad++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule